// File: doc/BRIEF.md
# Complementary PWM Timer Core

This block is the counting engine of a three-phase motor PWM generator. It keeps two main counters, a leading one and a trailing one, that run as a pair. Both move up and down in a triangle carrier. The leading counter stays ahead of the trailing one by a programmed dead-time offset, so that comparators further down the chip can place the complementary switch edges with a guaranteed gap between them.

A subcounter sets the carrier shape. It climbs from zero to the half-period value held in the period register, turns round, and descends to zero. A one-clock zero flag marks each trough. A shadow register holds the next half-period. It is copied into the active period register at the crest, at the trough, at both, or never, as chosen by a two-bit field in the control register. Software writes a new period at any time, and the carrier picks it up only at a turning point.

The host reaches the block over a 16-bit register bus. The bus has write and read strobes and a word-size qualifier, and only full 16-bit accesses are honoured. Register map, by `bus_addr`:
- 0 = control. Bit 0 is the run bit. Bits 2:1 are the transfer mode.
- 1 = dead time
- 2 = half period
- 3 = period shadow
- 4 = subcounter, read-only
- 5 = leading counter, read-only
- 6 = trailing counter, read-only

Top module: `cpwm_core`

## Requirements
- R1: After reset the control register reads 0, the dead time, half period and period shadow read 0xFFFF, and the subcounter and both main counters read 0x0000.
- R2: A write with `bus_word` low changes no register. A read with `bus_word` low returns 0x0000.
- R3: Writes to addresses 4, 5 and 6 are ignored. The counters there can only be read.
- R4: A control write that sets bit 0 while the block is stopped causes a restart. On the following clock the leading counter holds the dead time, the trailing counter and the subcounter hold 0, and counting then proceeds upward.
- R5: While running, the subcounter steps by one on every clock. When it equals the half period while rising, it turns and descends. When it reaches 0 while descending, it turns and climbs again.
- R6: `zero_pulse` is high for exactly the one clock in which the running subcounter is 0 on its descent, and it is low at all other times.
- R7: While running, the leading counter minus the trailing counter equals the dead time, and both main counters move in the same direction as the subcounter.
- R8: Writing 0 to control bit 0 freezes all three counters at the values they take on that clock. Setting bit 0 again performs the R4 preload.
- R9: When a turning point is reached, the period shadow is copied into the half-period register according to the mode in bits 2:1. The modes are 00 = copy at the crest, 01 = copy at the trough, 10 = copy at both, 11 = never. No copy takes place while the block is stopped.
- R10: If a shadow write lands in the same clock as a scheduled copy, the half-period register takes the previous shadow value, and the new value waits for the next copy point. A copy also wins over a direct half-period write in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | High for a full 16-bit access |
| bus_rdata | output | 16 | Read data, valid in the same cycle as `bus_rd` |
| zero_pulse | output | 1 | One-clock flag at each carrier trough |

## Verification
The checks on the carrier assume three things about the host. The half period is at least 1. The dead time is written only while the block is stopped. A half period that shrinks below the current subcounter value is never copied in during the rise. The bench loads dead time and half period only between a stop and a restart, and it uses shadow values of 3 or more. All host traffic passes through one stepping routine that updates an independent model of the bus, the counters and the copy rule on each clock. The R10 collision is produced by waiting until the model reaches a crest and writing the shadow in that very cycle.

// File: rtl/cpwm_core.sv
module cpwm_core #(
  parameter int W  = 16,
  parameter int AW = 3,
  parameter logic [W-1:0] DEAD_RST = '1,
  parameter logic [W-1:0] HALF_RST = '1,
  parameter logic [W-1:0] SHAD_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_word,
  output logic [W-1:0]  bus_rdata,
  output logic          zero_pulse
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_DEAD  = AW'(1);
  localparam logic [AW-1:0] A_HALF  = AW'(2);
  localparam logic [AW-1:0] A_SHAD  = AW'(3);
  localparam logic [AW-1:0] A_SUB   = AW'(4);
  localparam logic [AW-1:0] A_LEAD  = AW'(5);
  localparam logic [AW-1:0] A_TRAIL = AW'(6);

  logic         run, up_q;
  logic [1:0]   mode;
  logic [W-1:0] dead_q, half_q, shad_q, sub_q, lead_q, trail_q;

  wire wok     = bus_wr & bus_word;
  wire w_ctrl  = wok & (bus_addr == A_CTRL);
  wire w_dead  = wok & (bus_addr == A_DEAD);
  wire w_half  = wok & (bus_addr == A_HALF);
  wire w_shad  = wok & (bus_addr == A_SHAD);
  wire restart = w_ctrl & bus_wdata[0] & ~run;

  wire crest   = run & up_q & (sub_q == half_q);
  wire trough  = run & ~up_q & (sub_q == '0);
  wire xfer    = (crest & ~mode[0]) | (trough & (mode[0] ^ mode[1]));
  wire next_up = crest ? 1'b0 : (trough ? 1'b1 : up_q);

  assign zero_pulse = trough;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      mode    <= 2'b00;
      dead_q  <= DEAD_RST;
      half_q  <= HALF_RST;
      shad_q  <= SHAD_RST;
    end else begin
      if (w_ctrl) begin
        run  <= bus_wdata[0];
        mode <= bus_wdata[2:1];
      end
      if (w_dead) dead_q <= bus_wdata;
      if (w_shad) shad_q <= bus_wdata;
      if (xfer) half_q <= shad_q;
      else if (w_half) half_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= 1'b1;
      sub_q   <= '0;
      lead_q  <= '0;
      trail_q <= '0;
    end else if (restart) begin
      up_q    <= 1'b1;
      sub_q   <= '0;
      lead_q  <= dead_q;
      trail_q <= '0;
    end else if (run) begin
      up_q    <= next_up;
      sub_q   <= next_up ? sub_q + 1'b1 : sub_q - 1'b1;
      lead_q  <= next_up ? lead_q + 1'b1 : lead_q - 1'b1;
      trail_q <= next_up ? trail_q + 1'b1 : trail_q - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && bus_word) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {{(W-3){1'b0}}, mode, run};
        A_DEAD:  bus_rdata = dead_q;
        A_HALF:  bus_rdata = half_q;
        A_SHAD:  bus_rdata = shad_q;
        A_SUB:   bus_rdata = sub_q;
        A_LEAD:  bus_rdata = lead_q;
        A_TRAIL: bus_rdata = trail_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_byte_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_word && !run) |=>
      ($stable(dead_q) && $stable(half_q) && $stable(shad_q) && $stable(mode) && $stable(run)));

  assert_restart_preload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (lead_q == dead_q && trail_q == '0 && sub_q == '0));

  assert_zero_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |=> !zero_pulse);

  assert_gap_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(dead_q)) |-> ((lead_q - trail_q) == $past(lead_q - trail_q)));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> ($stable(sub_q) && $stable(lead_q) && $stable(trail_q)));

  assert_no_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b11 || !run) && !w_half) |=> $stable(half_q));
endmodule

// File: tb/cpwm_core_test.sv
`timescale 1ns/100ps
module cpwm_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_rdata;
  logic        zero_pulse;

  cpwm_core uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                 .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
                 .bus_rdata(bus_rdata), .zero_pulse(zero_pulse));

  always #4 clk = ~clk;

  int nvec = 0, nbad = 0;

  // {is_read, word, addr, data, expected}
  localparam int NV = 22;
  localparam logic [36:0] VEC [0:NV-1] = '{
    {1'b1, 1'b1, 3'd0, 16'h0000, 16'h0000},  // R1
    {1'b1, 1'b1, 3'd1, 16'h0000, 16'hFFFF},  // R1
    {1'b1, 1'b1, 3'd2, 16'h0000, 16'hFFFF},  // R1
    {1'b1, 1'b1, 3'd3, 16'h0000, 16'hFFFF},  // R1
    {1'b1, 1'b1, 3'd4, 16'h0000, 16'h0000},  // R1
    {1'b1, 1'b1, 3'd5, 16'h0000, 16'h0000},  // R1
    {1'b1, 1'b1, 3'd6, 16'h0000, 16'h0000},  // R1
    {1'b0, 1'b0, 3'd1, 16'h1234, 16'h0000},  // R2 byte write
    {1'b1, 1'b1, 3'd1, 16'h0000, 16'hFFFF},  // R2
    {1'b1, 1'b0, 3'd1, 16'h0000, 16'h0000},  // R2 byte read
    {1'b0, 1'b1, 3'd1, 16'h0005, 16'h0000},
    {1'b1, 1'b1, 3'd1, 16'h0000, 16'h0005},
    {1'b0, 1'b1, 3'd4, 16'h00AA, 16'h0000},  // R3
    {1'b1, 1'b1, 3'd4, 16'h0000, 16'h0000},  // R3
    {1'b0, 1'b1, 3'd5, 16'h0077, 16'h0000},  // R3
    {1'b1, 1'b1, 3'd5, 16'h0000, 16'h0000},  // R3
    {1'b0, 1'b1, 3'd2, 16'h0003, 16'h0000},
    {1'b1, 1'b1, 3'd2, 16'h0000, 16'h0003},
    {1'b0, 1'b1, 3'd3, 16'h0006, 16'h0000},
    {1'b0, 1'b0, 3'd3, 16'h1111, 16'h0000},  // R2
    {1'b0, 1'b1, 3'd0, 16'h0006, 16'h0000},
    {1'b1, 1'b1, 3'd0, 16'h0000, 16'h0006}
  };

  logic        m_run, m_up;
  logic [1:0]  m_mode;
  logic [15:0] m_dead, m_half, m_shad, m_sub, m_lead, m_trail;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input string req);
    bus_rd = 1'b1; bus_word = 1'b1;
    bus_addr = 3'd4; #0.5 check(req, bus_rdata, m_sub);
    bus_addr = 3'd5; #0.5 check(req, bus_rdata, m_lead);
    bus_addr = 3'd6; #0.5 check(req, bus_rdata, m_trail);
    bus_addr = 3'd2; #0.5 check(req, bus_rdata, m_half);
    check(req, {15'd0, zero_pulse}, {15'd0, m_run && !m_up && m_sub == 16'd0});
    bus_rd = 1'b0;
  endtask

  task automatic step(input string req, input logic dw, input logic [2:0] a, input logic [15:0] d);
    logic r0, cr, tr, xf, nu;
    peek(req);
    if (dw) begin
      bus_addr = a; bus_wdata = d; bus_word = 1'b1; bus_wr = 1'b1;
    end
    r0 = m_run;
    cr = m_run && m_up && m_sub == m_half;
    tr = m_run && !m_up && m_sub == 16'd0;
    xf = (cr && (m_mode == 2'd0 || m_mode == 2'd2)) || (tr && (m_mode == 2'd1 || m_mode == 2'd2));
    if (m_run) begin
      nu = cr ? 1'b0 : (tr ? 1'b1 : m_up);
      m_sub   = nu ? m_sub + 16'd1 : m_sub - 16'd1;
      m_lead  = nu ? m_lead + 16'd1 : m_lead - 16'd1;
      m_trail = nu ? m_trail + 16'd1 : m_trail - 16'd1;
      m_up    = nu;
    end
    if (xf) m_half = m_shad;
    else if (dw && a == 3'd2) m_half = d;
    if (dw && a == 3'd3) m_shad = d;
    if (dw && a == 3'd0) begin
      if (d[0] && !r0) begin
        m_sub = 16'd0; m_up = 1'b1; m_lead = m_dead; m_trail = 16'd0;
      end
      m_run = d[0]; m_mode = d[2:1];
    end
    if (dw && a == 3'd1) m_dead = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_addr = VEC[i][34:32]; bus_word = VEC[i][35]; bus_wdata = VEC[i][31:16];
      if (VEC[i][36]) begin
        bus_rd = 1'b1;
        #1 check(VEC[i][35] ? "R1/R3 register read" : "R2 byte read", bus_rdata, VEC[i][15:0]);
        bus_rd = 1'b0;
      end else begin
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
      end
    end

    m_run = 1'b0; m_up = 1'b1; m_mode = 2'd3;
    m_dead = 16'd5; m_half = 16'd3; m_shad = 16'd6;
    m_sub = 16'd0; m_lead = 16'd0; m_trail = 16'd0;
    @(negedge clk);

    step("R4", 1'b1, 3'd0, 16'h0007);
    step("R4", 1'b0, 3'd0, 16'h0000);
    for (int i = 0; i < 8; i++) step("R5", 1'b0, 3'd0, 16'h0000);
    for (int i = 0; i < 7; i++) step("R6", 1'b0, 3'd0, 16'h0000);
    for (int i = 0; i < 7; i++) step("R7", 1'b0, 3'd0, 16'h0000);

    step("R8", 1'b1, 3'd0, 16'h0006);
    for (int i = 0; i < 4; i++) step("R8", 1'b0, 3'd0, 16'h0000);
    step("R8", 1'b1, 3'd0, 16'h0007);
    for (int i = 0; i < 4; i++) step("R8", 1'b0, 3'd0, 16'h0000);

    for (int m = 0; m < 4; m++) begin
      step("R9", 1'b1, 3'd0, 16'(m * 2));
      step("R9", 1'b1, 3'd2, 16'd3);
      step("R9", 1'b1, 3'd3, 16'(5 + m));
      step("R9", 1'b1, 3'd0, 16'(m * 2 + 1));
      for (int i = 0; i < 18; i++) step("R9", 1'b0, 3'd0, 16'h0000);
    end

    step("R10", 1'b1, 3'd0, 16'h0000);
    step("R10", 1'b1, 3'd2, 16'd3);
    step("R10", 1'b1, 3'd3, 16'd4);
    step("R10", 1'b1, 3'd0, 16'h0001);
    for (int k = 0; k < 12 && !(m_up && m_sub == m_half); k++) step("R10", 1'b0, 3'd0, 16'h0000);
    step("R10", 1'b1, 3'd3, 16'd9);
    for (int i = 0; i < 14; i++) step("R10", 1'b0, 3'd0, 16'h0000);
    check("R10 final half", m_half, 16'd9);
    bus_rd = 1'b1; bus_word = 1'b1; bus_addr = 3'd3;
    #0.5 check("R10 shadow", bus_rdata, 16'd9);
    bus_rd = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule